// File: doc/BRIEF.md
# Phase-Adjustable Clock Channel Divider

This block is one channel of a clock distribution tree. It runs on a fast clock `clk` at twice the rate of the divider's nominal input clock. One `clk` cycle is therefore half a period of that input clock, and every output change lands on a `clk` rising edge, so the output cannot glitch. The channel divides by a 10-bit integer ratio N that arrives as a low byte and a high pair of bits. The output is high for N `clk` cycles and low for N `clk` cycles, so the duty cycle is exactly 50% for odd N as well as even N. A programmable start delay of 0 to 63 half periods shifts the waveform, and an invert control flips its polarity.

Channels are aligned to one another by holding them and then releasing them on the same edge. Three conditions hold the channel with its output low: a channel power-down, a PLL-ready indication that is low, and a software sync bit that is set on a channel that does not ignore it. The channel is released when the sync bit is cleared or when PLL-ready rises, and it then starts from its programmed delay. A channel with its ignore flag set keeps running through software sync activity. The divide ratio, delay and invert setting are captured at each release, and writes made while the channel runs take effect at the next release.

Top module: `ckdiv_channel`

## Requirements
- R1: With effective ratio N (N = {div_hi, div_lo}, where div_hi holds bits 9:8), the running output repeats every 2N `clk` cycles, with up to N = 1023.
- R2: Within each period the output is high for exactly N `clk` cycles and then low for N cycles, for odd N as well as even N.
- R3: A ratio field of 0 or 1 gives divide-by-1 (the output toggles on every `clk` edge), and in that case the phase field is ignored.
- R4: Take edge E as the `clk` edge at which the hold condition is first sampled low. With a phase field p, the output shows the inactive level after edges E to E+p-1 and goes active for the first time after edge E+p.
- R5: With invert set, the running waveform, including the inactive level during the start delay, is the complement of the non-inverted one.
- R6: While sync_ctl is 1 and sync_ignore is 0, the output is low from the next edge onward. Clearing sync_ctl, the 1-to-0 transition, releases the channel as defined in R4.
- R7: While sync_ignore is 1, setting and clearing sync_ctl does not disturb the running waveform.
- R8: While pll_ready is 0, the output is low from the next edge onward. The rise of pll_ready releases the channel as defined in R4.
- R9: While power_down is 1, the output is low from the next edge onward. When power_down is cleared, the channel restarts as a release.
- R10: The ratio, phase and invert fields are captured at release. Changing them while the channel runs does not alter the waveform until the next release.
- R11: While rst_n is low the output is 0. The first edge after reset with no hold condition is a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the divider input rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo | input | 8 | Divide ratio bits 7:0 |
| div_hi | input | 2 | Divide ratio bits 9:8 |
| phase | input | 6 | Start delay in half input periods |
| invert | input | 1 | Flip output polarity |
| sync_ignore | input | 1 | Channel ignores software sync |
| power_down | input | 1 | Hold the channel with its output low |
| sync_ctl | input | 1 | Software sync bit; a set bit holds the channel, and clearing it releases it |
| pll_ready | input | 1 | Upstream PLL ready; low holds the channel, and its rise releases it |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong state in the sequencer shows at `clk_out` within one period of the programmed waveform. A start counter that is off by one moves the first active edge by one `clk` cycle after release. A mistake at the period wrap shows as a high or low run of the wrong length, and the bench compares every sample of a window after release against a model. A hold path that fails leaves the output toggling one edge after power-down, a set sync bit or a low PLL-ready. A configuration that is not captured at release shows as a changed period in the same window where the bench changes the fields.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    typedef enum logic [1:0] {
        CH_HOLD = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/ckdiv_hold.sv
module ckdiv_hold (
    input  logic power_down,
    input  logic pll_ready,
    input  logic sync_ctl,
    input  logic sync_ignore,
    output logic hold
);
    // A set software sync bit only holds channels that do not opt out.
    logic sw_hold;
    always_comb begin
        sw_hold = sync_ctl & ~sync_ignore;
        hold    = power_down | ~pll_ready | sw_hold;
    end
endmodule

// File: rtl/ckdiv_seq.sv
module ckdiv_seq
    import ckdiv_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [PH_W-1:0]  phase,
    input  logic             invert,
    output logic             wave
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        ch_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  wcnt;
        logic [DIV_W-1:0] n;
        logic             inv;
        logic             out;
    } seq_t;

    seq_t q, d;

    logic [DIV_W-1:0] n_eff;
    logic [PH_W-1:0]  p_eff;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        n_eff = (div_ratio <= DIV_W'(1)) ? DIV_W'(1) : div_ratio;
        p_eff = (n_eff == DIV_W'(1)) ? '0 : phase;
        last  = {q.n, 1'b0} - CNT_W'(1);
        nxt   = (q.cnt == last) ? '0 : q.cnt + CNT_W'(1);

        d = q;
        if (hold) begin
            d.state = CH_HOLD;
            d.cnt   = '0;
            d.wcnt  = '0;
            d.out   = 1'b0;
        end else begin
            unique case (q.state)
                CH_HOLD: begin
                    // release: capture configuration for this run
                    d.n   = n_eff;
                    d.inv = invert;
                    d.cnt = '0;
                    if (p_eff == '0) begin
                        d.state = CH_RUN;
                        d.out   = ~invert;
                    end else begin
                        d.state = CH_WAIT;
                        d.wcnt  = p_eff - PH_W'(1);
                        d.out   = invert;
                    end
                end
                CH_WAIT: begin
                    if (q.wcnt == '0) begin
                        d.state = CH_RUN;
                        d.cnt   = '0;
                        d.out   = ~q.inv;
                    end else begin
                        d.wcnt = q.wcnt - PH_W'(1);
                        d.out  = q.inv;
                    end
                end
                CH_RUN: begin
                    d.cnt = nxt;
                    d.out = (nxt < {1'b0, q.n}) ^ q.inv;
                end
                default: begin
                    d.state = CH_HOLD;
                    d.out   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: CH_HOLD, cnt: '0, wcnt: '0, n: DIV_W'(1), inv: 1'b0, out: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wave = q.out;
endmodule

// File: rtl/ckdiv_channel.sv
module ckdiv_channel #(
    parameter int LO_W  = 8,
    parameter int DIV_W = 10,
    parameter int PH_W  = 6,
    localparam int HI_W = DIV_W - LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LO_W-1:0] div_lo,
    input  logic [HI_W-1:0] div_hi,
    input  logic [PH_W-1:0] phase,
    input  logic            invert,
    input  logic            sync_ignore,
    input  logic            power_down,
    input  logic            sync_ctl,
    input  logic            pll_ready,
    output logic            clk_out
);
    logic             hold;
    logic [DIV_W-1:0] div_ratio;

    assign div_ratio = {div_hi, div_lo};

    ckdiv_hold u_hold (
        .power_down (power_down),
        .pll_ready  (pll_ready),
        .sync_ctl   (sync_ctl),
        .sync_ignore(sync_ignore),
        .hold       (hold)
    );

    ckdiv_seq #(
        .DIV_W(DIV_W),
        .PH_W (PH_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .div_ratio(div_ratio),
        .phase    (phase),
        .invert   (invert),
        .wave     (clk_out)
    );
endmodule

// File: rtl/ckdiv_channel_chk.sv
module ckdiv_channel_chk #(
    parameter int PH_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PH_W-1:0] phase,
    input logic            invert,
    input logic            sync_ignore,
    input logic            power_down,
    input logic            sync_ctl,
    input logic            pll_ready,
    input logic            clk_out
);
    logic hold_c;
    assign hold_c = power_down | !pll_ready | (sync_ctl & !sync_ignore);

    assert_pd_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> !clk_out);

    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ctl && !sync_ignore) |=> !clk_out);

    assert_rdy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_ready |=> !clk_out);

    assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_c) && phase == '0 && !invert) |=> clk_out);

    assert_start_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_c) && phase == '0 && invert) |=> !clk_out);
endmodule

bind ckdiv_channel ckdiv_channel_chk #(.PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .invert     (invert),
    .sync_ignore(sync_ignore),
    .power_down (power_down),
    .sync_ctl   (sync_ctl),
    .pll_ready  (pll_ready),
    .clk_out    (clk_out)
);

// File: tb/ckdiv_channel_tb.sv
module ckdiv_channel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'd4;
    logic [1:0] div_hi = 2'd0;
    logic [5:0] phase = 6'd0;
    logic       invert = 1'b0;
    logic       sync_ignore = 1'b0;
    logic       power_down = 1'b0;
    logic       sync_ctl = 1'b0;
    logic       pll_ready = 1'b1;
    logic       clk_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ckdiv_channel u_dut (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .phase(phase), .invert(invert), .sync_ignore(sync_ignore),
        .power_down(power_down), .sync_ctl(sync_ctl), .pll_ready(pll_ready),
        .clk_out(clk_out)
    );

    // {ratio[9:0], phase[5:0], invert}
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        {10'd4,    6'd0,  1'b0},   // R1 even ratio
        {10'd3,    6'd0,  1'b0},   // R2 odd ratio duty
        {10'd5,    6'd2,  1'b0},   // R2 R4
        {10'd1,    6'd7,  1'b0},   // R3 phase ignored
        {10'd0,    6'd3,  1'b0},   // R3 zero ratio
        {10'd2,    6'd1,  1'b1},   // R5 invert
        {10'd7,    6'd63, 1'b1},   // R4 R5 max delay
        {10'd1023, 6'd5,  1'b0},   // R1 max ratio
        {10'd256,  6'd0,  1'b0}    // R1 high ratio bits
    };

    function automatic logic model(int n_raw, int p, logic inv, int k);
        int n;
        int pe;
        n  = (n_raw <= 1) ? 1 : n_raw;
        pe = (n == 1) ? 0 : p;
        if (k < pe) return inv;
        return logic'(((k - pe) % (2 * n)) < n) ^ inv;
    endfunction

    task automatic set_cfg(int n, int p, logic inv);
        logic [9:0] v;
        v = 10'(n);
        div_lo = v[7:0];
        div_hi = v[9:8];
        phase  = 6'(p);
        invert = inv;
    endtask

    // samples k0..k1-1 counted from release edge E; one check per call
    task automatic win(int n, int p, logic inv, int k0, int k1, string tag);
        int bad = 0;
        int bk = 0;
        logic ba = 1'b0;
        logic be = 1'b0;
        for (int k = k0; k < k1; k++) begin
            @(negedge clk);
            if (clk_out !== model(n, p, inv, k)) begin
                if (bad == 0) begin bk = k; ba = clk_out; be = model(n, p, inv, k); end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: sample %0d actual=%b expected=%b (%0d mismatches)", tag, bk, ba, be, bad);
        end
    endtask

    // hold via sync, load config, then clear sync at a negedge
    task automatic release_with(int n, int p, logic inv);
        @(negedge clk);
        sync_ctl = 1'b1;
        set_cfg(n, p, inv);
        @(negedge clk);
        @(negedge clk);
        sync_ctl = 1'b0;
    endtask

    task automatic expect_low(int cyc, string tag);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (clk_out !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: actual=1 expected=0 on %0d samples", tag, bad);
        end
    endtask

    initial begin
        // R11: reset state
        expect_low(4, "R11 reset");
        rst_n = 1'b1;               // release edge at next posedge, cfg 4/0/0
        win(4, 0, 1'b0, 0, 20, "R11 first release");

        // table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            int n;
            int p;
            n = int'(VEC[i][16:7]);
            p = int'(VEC[i][6:1]);
            release_with(n, p, VEC[i][0]);
            win(n, p, VEC[i][0], 0, p + 4 * ((n <= 1) ? 1 : n) + 4,
                $sformatf("R1/R2/R3/R4/R5 vec%0d", i));
        end

        // R6: sync held low, then released on clearing
        @(negedge clk);
        set_cfg(6, 3, 1'b0);
        sync_ctl = 1'b1;
        expect_low(8, "R6 sync held");
        sync_ctl = 1'b0;
        win(6, 3, 1'b0, 0, 30, "R6 release on clear");

        // R7: ignoring channel keeps running through sync activity
        release_with(4, 0, 1'b0);
        win(4, 0, 1'b0, 0, 10, "R7 pre");
        sync_ignore = 1'b1;
        sync_ctl = 1'b1;
        win(4, 0, 1'b0, 10, 20, "R7 during set");
        sync_ctl = 1'b0;
        win(4, 0, 1'b0, 20, 40, "R7 after clear");
        sync_ignore = 1'b0;

        // R10: config changes while running are ignored until release
        release_with(5, 1, 1'b0);
        win(5, 1, 1'b0, 0, 7, "R10 pre");
        set_cfg(3, 9, 1'b1);
        win(5, 1, 1'b0, 7, 40, "R10 ignored while running");
        release_with(3, 9, 1'b1);
        win(3, 9, 1'b1, 0, 30, "R10 new config at release");

        // R8: pll_ready low holds, rise releases
        @(negedge clk);
        set_cfg(6, 2, 1'b0);
        pll_ready = 1'b0;
        expect_low(6, "R8 not ready");
        pll_ready = 1'b1;
        win(6, 2, 1'b0, 0, 30, "R8 release on ready");

        // R9: power-down low, restart as release
        win(6, 2, 1'b0, 30, 35, "R9 pre");
        power_down = 1'b1;
        expect_low(10, "R9 powered down");
        set_cfg(2, 4, 1'b1);
        power_down = 1'b0;
        win(2, 4, 1'b1, 0, 20, "R9 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule